// File: doc/BRIEF.md
# Register-Machine ALU Execution Unit

This block is the arithmetic stage of a 64-bit register-machine pipeline. Each accepted beat carries one decoded 8-bit opcode, the current value of the destination register, the current value of the source register and the instruction's 32-bit immediate. One clock later the block presents the value to write back into the destination register. It also reports whether the operation divided by zero and whether the opcode was one it does not execute.

The opcode fields work as follows. The low three bits give the class. Bit 3 chooses between the immediate and the source register as the second operand. The top four bits name the operation. The same operation map serves a full-width class and a half-width class; the half-width class clears the upper word of its result. The half-width class also carries the two endian conversion operations, which take their width from the immediate. Instruction fetch, the register file, memory access and branching belong to other stages.

Top module: `regmach_alu`

## Requirements
- R1: Opcode bits [2:0] = 7 select full-width (64-bit) operation and bits [2:0] = 4 select half-width (32-bit) operation; any other value of bits [2:0] is treated as illegal.
- R2: Opcode bit 3 = 1 takes the source register as the second operand and bit 3 = 0 takes the immediate; in the 64-bit class the 32-bit immediate is sign-extended to 64 bits.
- R3: Half-width operations use only bits [31:0] of each operand and write their 32-bit result zero-extended, so result[63:32] = 0.
- R4: Opcode bits [7:4] select add 0x0, sub 0x1, mul 0x2, or 0x4, and 0x5, xor 0xa and mov 0xb (result = second operand), with results wrapping modulo the operating width.
- R5: Opcode bits [7:4] = 0x6 shift left, 0x7 shift right with zero fill, and 0xc shift right with copies of the sign bit (bit 63, or bit 31 for half width); the shift amount is the second operand masked to 6 bits (64-bit) or 5 bits (32-bit).
- R6: Opcode bits [7:4] = 0x8 returns the two's-complement negation of the destination operand, and the second operand has no effect on it.
- R7: Opcode bits [7:4] = 0x3 (divide) and 0x9 (remainder) treat both operands as unsigned.
- R8: With a zero divisor (after masking to 32 bits in the half-width class), divide returns 0, remainder returns the destination operand (its low word zero-extended in the half-width class), and div_zero is 1 for that result beat only.
- R9: Opcode 0xd4 returns the low 16, 32 or 64 bits of dst unchanged, and opcode 0xdc returns them with their byte order reversed, in both cases with all higher bits cleared; the width is chosen by an immediate of exactly 16, 32 or 64.
- R10: Operation codes 0xd to 0xf in the 64-bit class, 0xe and 0xf in the 32-bit class, a conversion opcode with any other immediate, and any other class raise illegal, return dst unchanged and keep div_zero at 0.
- R11: Result, div_zero and illegal are registered and appear one clock after an accepted beat with out_valid = 1; without a beat out_valid, div_zero and illegal are 0; reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat present on the operand inputs |
| opcode | input | 8 | Decoded instruction opcode |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Instruction immediate |
| out_valid | output | 1 | Result beat present |
| result | output | 64 | Value to write back to the destination |
| div_zero | output | 1 | Divide or remainder by zero on this beat |
| illegal | output | 1 | Opcode not executed; result equals dst |

## Verification
Directed vectors use operand values that set bit 31 or bit 63. This separates sign-extended from zero-extended immediates, logical from arithmetic shifts, and signed from unsigned division. Shift amounts above the width check the masking. Dirty upper destination words show whether the half-width forms clear the top. Neg is given a nonzero source to show the source is ignored. Every conversion width is tried, along with an invalid one. A long run of random opcodes across all 256 values, with random operands, is compared each clock against a behavioural model. That run catches cross-talk between operations and errors in the illegal decode.

// File: rtl/regmach_alu.sv
module regmach_alu (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  opcode,
  input  logic [63:0] dst_val,
  input  logic [63:0] src_val,
  input  logic [31:0] imm,
  output logic        out_valid,
  output logic [63:0] result,
  output logic        div_zero,
  output logic        illegal
);
  localparam int W  = 64;
  localparam int HW = 32;

  localparam logic [3:0] OP_ADD  = 4'h0;
  localparam logic [3:0] OP_SUB  = 4'h1;
  localparam logic [3:0] OP_MUL  = 4'h2;
  localparam logic [3:0] OP_DIV  = 4'h3;
  localparam logic [3:0] OP_OR   = 4'h4;
  localparam logic [3:0] OP_AND  = 4'h5;
  localparam logic [3:0] OP_LSH  = 4'h6;
  localparam logic [3:0] OP_RSH  = 4'h7;
  localparam logic [3:0] OP_NEG  = 4'h8;
  localparam logic [3:0] OP_MOD  = 4'h9;
  localparam logic [3:0] OP_XOR  = 4'ha;
  localparam logic [3:0] OP_MOV  = 4'hb;
  localparam logic [3:0] OP_ARSH = 4'hc;
  localparam logic [3:0] OP_SWAP = 4'hd;

  logic [3:0] op;
  logic       cls_full, cls_half, use_reg, op_known;
  assign op       = opcode[7:4];
  assign use_reg  = opcode[3];
  assign cls_full = (opcode[2:0] == 3'd7);
  assign cls_half = (opcode[2:0] == 3'd4);
  assign op_known = (op <= OP_ARSH);

  // operands
  logic [W-1:0]  a64, b64;
  logic [HW-1:0] a32, b32;
  assign a64 = dst_val;
  assign b64 = use_reg ? src_val : {{(W-HW){imm[HW-1]}}, imm};
  assign a32 = dst_val[HW-1:0];
  assign b32 = use_reg ? src_val[HW-1:0] : imm;

  // full-width datapath
  logic [5:0]   sh64;
  logic         dz64;
  logic [W-1:0] r64;
  assign sh64 = b64[5:0];
  assign dz64 = (b64 == '0);

  always_comb begin
    case (op)
      OP_ADD:  r64 = a64 + b64;
      OP_SUB:  r64 = a64 - b64;
      OP_MUL:  r64 = a64 * b64;
      OP_DIV:  r64 = dz64 ? '0 : a64 / b64;
      OP_OR:   r64 = a64 | b64;
      OP_AND:  r64 = a64 & b64;
      OP_LSH:  r64 = a64 << sh64;
      OP_RSH:  r64 = a64 >> sh64;
      OP_NEG:  r64 = '0 - a64;
      OP_MOD:  r64 = dz64 ? a64 : a64 % b64;
      OP_XOR:  r64 = a64 ^ b64;
      OP_MOV:  r64 = b64;
      OP_ARSH: r64 = W'($signed(a64) >>> sh64);
      default: r64 = a64;
    endcase
  end

  // half-width datapath
  logic [4:0]    sh32;
  logic          dz32;
  logic [HW-1:0] r32;
  assign sh32 = b32[4:0];
  assign dz32 = (b32 == '0);

  always_comb begin
    case (op)
      OP_ADD:  r32 = a32 + b32;
      OP_SUB:  r32 = a32 - b32;
      OP_MUL:  r32 = a32 * b32;
      OP_DIV:  r32 = dz32 ? '0 : a32 / b32;
      OP_OR:   r32 = a32 | b32;
      OP_AND:  r32 = a32 & b32;
      OP_LSH:  r32 = a32 << sh32;
      OP_RSH:  r32 = a32 >> sh32;
      OP_NEG:  r32 = '0 - a32;
      OP_MOD:  r32 = dz32 ? a32 : a32 % b32;
      OP_XOR:  r32 = a32 ^ b32;
      OP_MOV:  r32 = b32;
      OP_ARSH: r32 = HW'($signed(a32) >>> sh32);
      default: r32 = a32;
    endcase
  end

  // endian conversion
  logic         sw16, sw32, sw64, sw_ok, swap_op;
  logic [W-1:0] rev64, rsw;
  assign sw16    = (imm == 32'd16);
  assign sw32    = (imm == 32'd32);
  assign sw64    = (imm == 32'd64);
  assign sw_ok   = sw16 | sw32 | sw64;
  assign swap_op = cls_half && (op == OP_SWAP);

  always_comb begin
    for (int k = 0; k < W/8; k++)
      rev64[8*k +: 8] = dst_val[8*(W/8-1-k) +: 8];
  end

  always_comb begin
    if (!use_reg) begin
      if (sw16)      rsw = {48'b0, dst_val[15:0]};
      else if (sw32) rsw = {32'b0, dst_val[31:0]};
      else           rsw = dst_val;
    end else begin
      if (sw16)      rsw = {48'b0, rev64[63:48]};
      else if (sw32) rsw = {32'b0, rev64[63:32]};
      else           rsw = rev64;
    end
  end

  // selection
  logic         bad, dz;
  logic [W-1:0] rnext;
  assign bad = !((cls_full && op_known) ||
                 (cls_half && op_known) ||
                 (swap_op && sw_ok));
  assign dz  = !bad && ((op == OP_DIV) || (op == OP_MOD)) &&
               (cls_full ? dz64 : dz32);

  always_comb begin
    if (bad)          rnext = dst_val;
    else if (swap_op) rnext = rsw;
    else if (cls_half) rnext = {{(W-HW){1'b0}}, r32};
    else              rnext = r64;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      div_zero  <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      div_zero  <= in_valid && dz;
      illegal   <= in_valid && bad;
      if (in_valid) result <= rnext;
    end
  end

  // R10
  illegal_keeps_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && bad |=> illegal && out_valid && !div_zero && result == $past(dst_val));

  // R8
  div_zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> out_valid && !illegal);

  // R3
  upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && cls_half && op != OP_SWAP && op_known |=> result[63:32] == 32'h0);

  // R6
  neg_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && opcode == 8'h87 |=> result == 64'h0 - $past(dst_val));

  // R2
  mov_imm_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && opcode == 8'hb7 |=> result == {{32{$past(imm[31])}}, $past(imm)});

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !div_zero && !illegal);
endmodule

// File: tb/sim_regmach_alu.sv
module sim_regmach_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode = '0;
  logic [63:0] dst_val = '0, src_val = '0;
  logic [31:0] imm = '0;
  logic        out_valid, div_zero, illegal;
  logic [63:0] result;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  regmach_alu u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .dst_val(dst_val), .src_val(src_val), .imm(imm),
    .out_valid(out_valid), .result(result), .div_zero(div_zero), .illegal(illegal)
  );

  function automatic void model(input logic [7:0] op, input logic [63:0] d, s,
                                input logic [31:0] im, output logic [63:0] r,
                                output bit ill, output bit dz);
    longint unsigned x, y;
    int unsigned     p, q;
    int              n;
    bit half = (op[2:0] == 3'd4);
    bit full = (op[2:0] == 3'd7);
    ill = 0; dz = 0; r = d;
    x = d;
    y = op[3] ? s : longint'(signed'(im));
    p = d[31:0];
    q = op[3] ? s[31:0] : im;
    if (!half && !full) begin ill = 1; return; end
    if (half && op[7:4] == 4'hd) begin
      n = (im == 16) ? 2 : (im == 32) ? 4 : (im == 64) ? 8 : 0;
      if (n == 0) begin ill = 1; return; end
      r = '0;
      for (int k = 0; k < n; k++)
        if (op[3]) r[8*k +: 8] = d[8*(n-1-k) +: 8];
        else       r[8*k +: 8] = d[8*k +: 8];
      return;
    end
    if (op[7:4] > 4'hc) begin ill = 1; return; end
    if (full) begin
      case (op[7:4])
        0: r = x + y;
        1: r = x - y;
        2: r = x * y;
        3: begin dz = (y == 0); r = dz ? 0 : x / y; end
        4: r = x | y;
        5: r = x & y;
        6: r = x << (y % 64);
        7: r = x >> (y % 64);
        8: r = -x;
        9: begin dz = (y == 0); r = dz ? x : x % y; end
        10: r = x ^ y;
        11: r = y;
        default: r = longint'(signed'(x) >>> (y % 64));
      endcase
    end else begin
      int unsigned t;
      case (op[7:4])
        0: t = p + q;
        1: t = p - q;
        2: t = p * q;
        3: begin dz = (q == 0); t = dz ? 0 : p / q; end
        4: t = p | q;
        5: t = p & q;
        6: t = p << (q % 32);
        7: t = p >> (q % 32);
        8: t = -p;
        9: begin dz = (q == 0); t = dz ? p : p % q; end
        10: t = p ^ q;
        11: t = q;
        default: t = int'(signed'(p) >>> (q % 32));
      endcase
      r = {32'h0, t};
    end
  endfunction

  task automatic apply(input logic [7:0] op, input logic [63:0] d, s,
                       input logic [31:0] im, input string tag);
    logic [63:0] er;
    bit ei, ez;
    model(op, d, s, im, er, ei, ez);
    opcode = op; dst_val = d; src_val = s; imm = im; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    vectors++;
    if (out_valid !== 1'b1 || result !== er || illegal !== ei || div_zero !== ez) begin
      fails++;
      $display("FAIL %s op=%02h: got v=%0b r=%016h ill=%0b dz=%0b exp v=1 r=%016h ill=%0b dz=%0b",
               tag, op, out_valid, result, illegal, div_zero, er, ei, ez);
    end
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    vectors++;
    if (out_valid !== 1'b0 || div_zero !== 1'b0 || illegal !== 1'b0) begin
      fails++;
      $display("FAIL %s idle: got v=%0b dz=%0b ill=%0b exp 0 0 0", tag, out_valid, div_zero, illegal);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (out_valid !== 1'b0 || result !== 64'h0 || div_zero !== 1'b0 || illegal !== 1'b0) begin
      fails++;
      $display("FAIL R11 reset: got v=%0b r=%016h dz=%0b ill=%0b exp 0 0 0 0",
               out_valid, result, div_zero, illegal);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R2: sign-extended immediate vs register operand
    apply(8'h07, 64'd5, 64'd100, 32'hffff_ffff, "R2");
    apply(8'h0f, 64'd5, 64'd100, 32'hffff_ffff, "R2");
    apply(8'hb7, 64'h1234, 64'h0, 32'h8000_0000, "R2");
    // R1 R3: half-width wraps and clears top
    apply(8'h04, 64'hdead_beef_ffff_ffff, 64'h0, 32'd1, "R3");
    apply(8'hbc, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_8765_4321, 32'h0, "R3");
    apply(8'h1c, 64'h0, 64'd1, 32'h0, "R1");
    // R4
    apply(8'h1f, 64'd3, 64'd10, 32'h0, "R4");
    apply(8'h2f, 64'h1_0000_0001, 64'h1_0000_0003, 32'h0, "R4");
    apply(8'h47, 64'hf0, 64'h0, 32'h0f, "R4");
    apply(8'h5c, 64'hffff_0000_ff00_ff00, 64'h0f0f_0f0f, 32'h0, "R4");
    apply(8'haf, 64'haaaa, 64'hffff, 32'h0, "R4");
    // R5: masking and fill
    apply(8'h67, 64'h1, 64'h0, 32'd65, "R5");
    apply(8'h64, 64'h1, 64'h0, 32'd33, "R5");
    apply(8'h7f, 64'h8000_0000_0000_0000, 64'd4, 32'h0, "R5");
    apply(8'hcf, 64'h8000_0000_0000_0000, 64'd4, 32'h0, "R5");
    apply(8'hc4, 64'h0000_0000_8000_0000, 64'h0, 32'd4, "R5");
    apply(8'h74, 64'hffff_ffff_8000_0000, 64'h0, 32'd4, "R5");
    // R6
    apply(8'h8f, 64'd7, 64'd12345, 32'd99, "R6");
    apply(8'h84, 64'hffff_ffff_0000_0001, 64'd3, 32'h0, "R6");
    // R7: unsigned divide and remainder
    apply(8'h3f, 64'hffff_ffff_ffff_fff0, 64'd16, 32'h0, "R7");
    apply(8'h9f, 64'hffff_ffff_ffff_fff3, 64'd16, 32'h0, "R7");
    apply(8'h34, 64'h0, 64'h0, 32'hffff_fffe, "R7");
    apply(8'h94, 64'h8000_0007, 64'h0, 32'd10, "R7");
    // R8: zero divisors
    apply(8'h3f, 64'd77, 64'd0, 32'h0, "R8");
    apply(8'h9f, 64'hcafe_0000_0000_0077, 64'd0, 32'h0, "R8");
    apply(8'h9c, 64'hcafe_0000_0000_0077, 64'h5_0000_0000, 32'h0, "R8");
    apply(8'h37, 64'd9, 64'd0, 32'd0, "R8");
    apply(8'h07, 64'd1, 64'd0, 32'd1, "R8");
    // R9
    apply(8'hd4, 64'h0102_0304_0506_0708, 64'h0, 32'd16, "R9");
    apply(8'hd4, 64'h0102_0304_0506_0708, 64'h0, 32'd32, "R9");
    apply(8'hd4, 64'h0102_0304_0506_0708, 64'h0, 32'd64, "R9");
    apply(8'hdc, 64'h0102_0304_0506_0708, 64'h0, 32'd16, "R9");
    apply(8'hdc, 64'h0102_0304_0506_0708, 64'h0, 32'd32, "R9");
    apply(8'hdc, 64'h0102_0304_0506_0708, 64'h0, 32'd64, "R9");
    // R10
    apply(8'hdc, 64'h0102_0304_0506_0708, 64'h0, 32'd8, "R10");
    apply(8'hd7, 64'h55, 64'h0, 32'd16, "R10");
    apply(8'he4, 64'h66, 64'h0, 32'd1, "R10");
    apply(8'h3d, 64'h77, 64'h0, 32'd0, "R10");
    apply(8'h05, 64'h88, 64'h1, 32'd1, "R10");
    // R11
    idle_check("R11");
    idle_check("R11");
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] rop;
      logic [63:0] rd, rs;
      logic [31:0] ri;
      rop = 8'($urandom);
      if (i % 2 == 0) rop[2:0] = (i % 4 == 0) ? 3'd7 : 3'd4;
      rd = {$urandom, $urandom};
      rs = (i % 7 == 0) ? 64'h0 : {$urandom, $urandom};
      ri = (i % 5 == 0) ? 32'($urandom_range(0, 2) * 16 + 16) : $urandom;
      if (i % 11 == 0) ri = 32'h0;
      apply(rop, rd, rs, ri, "R4 random");
    end
    idle_check("R11");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule